// File: doc/BRIEF.md
# Pixel-Window Stream Scrambler

This stage sits on a pixel stream between a video capture block and a frame store. Each transfer beat carries one 24-bit RGB word, and the beat that starts a frame is marked with a start-of-packet flag. The handshake flags and frame markers pass straight through without delay. The stage never stalls the stream on its own: the ready signal from the downstream side is returned unchanged to the upstream side.

The stage numbers the pixels of each frame in scan order. The pixel carrying start-of-packet is number 0, and the number goes up by one for each transfer that completes. Pixels whose number falls inside a configurable inclusive window have their RGB word XORed with the current output of a 24-bit linear feedback shift register. That register steps once for each scrambled pixel and is reloaded with a fixed seed at the start of every frame. Because of this, a second identical stage placed downstream restores the original picture. Pixels outside the window pass through bit for bit.

Top module: `pix_xor_stage`

## Requirements
- R1: Source valid, start-of-packet and end-of-packet equal the sink's in the same cycle, and sink ready equals source ready in the same cycle.
- R2: A beat flagged start-of-packet has pixel index 0. After each completed transfer (valid and ready both high), the next beat's index is one more than the completed beat's index.
- R3: A beat whose index lies in the inclusive range START_IDX to END_IDX leaves with data equal to its input XOR the generator value assigned to it.
- R4: A beat whose index is below START_IDX or above END_IDX leaves with data identical to its input.
- R5: The generator is a Fibonacci shift register with next = {s[22:0], s[23]^s[22]^s[21]^s[16]}. It steps once per completed in-window transfer and never holds zero.
- R6: The generator holds SEED (default 24'hACE1F5) after reset, and is treated as SEED on every start-of-packet beat. The first scrambled pixel of each frame is therefore XORed with SEED.
- R7: While a beat is stalled (valid high and ready low), its index and its generator value stay unchanged, so its output data is stable.
- R8: The internal count stops at END_IDX+1. However long a frame runs past the window, its later pixels stay unscrambled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock |
| rst | input | 1 | Asynchronous reset, active high |
| snkData | input | 24 | Incoming RGB word |
| snkValid | input | 1 | Incoming beat valid |
| snkSop | input | 1 | Incoming first beat of frame |
| snkEop | input | 1 | Incoming last beat of frame |
| snkReady | output | 1 | Stage can take the incoming beat |
| srcData | output | 24 | Outgoing RGB word |
| srcValid | output | 1 | Outgoing beat valid |
| srcSop | output | 1 | Outgoing first beat of frame |
| srcEop | output | 1 | Outgoing last beat of frame |
| srcReady | input | 1 | Downstream accepts the outgoing beat |

## Verification
Two functions can land on the same beat: the start-of-packet reload of index and generator, and a stall. A stall can also fall on the first or last pixel of the window. The bench provokes these overlaps by holding start-of-packet beats and window-edge beats under random ready and valid stalls. It also starts new frames that cut off the previous frame inside the window, and runs frames that end exactly on the window bound. On every cycle it compares the output word with a bench model of the index and the generator that advances only on accepted beats. A stalled beat must therefore show the same word until it is accepted, and the first scrambled pixel after any start-of-packet must carry SEED.

// File: rtl/pix_xor_pkg.sv
package pix_xor_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic fire;      // transfer completes this cycle
    logic sop;       // current beat starts a frame
    logic inWindow;  // current beat is to be scrambled
  } scrStrobe_t;
endpackage

// File: rtl/pix_xor_ctrl.sv
module pix_xor_ctrl
  import pix_xor_pkg::*;
#(
  parameter int START_IDX = 1000,
  parameter int END_IDX   = 15000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       snkValid,
  input  logic       snkSop,
  input  logic       srcReady,
  output scrStrobe_t strb
);
  localparam int CNT_W = $clog2(END_IDX + 2);
  localparam logic [CNT_W-1:0] SAT_C   = CNT_W'(END_IDX + 1);
  localparam logic [CNT_W-1:0] START_C = CNT_W'(START_IDX);
  localparam logic [CNT_W-1:0] END_C   = CNT_W'(END_IDX);

  logic [CNT_W-1:0] pixCount;
  logic [CNT_W-1:0] curIdx;

  always_comb begin
    curIdx        = snkSop ? '0 : pixCount;
    strb.fire     = snkValid & srcReady;
    strb.sop      = snkSop;
    strb.inWindow = (curIdx >= START_C) && (curIdx <= END_C);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pixCount <= '0;
    end else if (strb.fire) begin
      pixCount <= (curIdx == SAT_C) ? SAT_C : CNT_W'(curIdx + 1'b1);
    end
  end

  assert_stall_idx_R7: assert property (@(posedge clk) disable iff (rst)
    !(snkValid && srcReady) |=> $stable(pixCount));

  assert_sop_restart_R2: assert property (@(posedge clk) disable iff (rst)
    (snkValid && srcReady && snkSop) |=> pixCount == CNT_W'(1));

  assert_count_cap_R8: assert property (@(posedge clk) disable iff (rst)
    pixCount <= SAT_C);
endmodule

// File: rtl/pix_xor_dpath.sv
module pix_xor_dpath
  import pix_xor_pkg::*;
#(
  parameter int                DATA_W   = 24,
  parameter logic [DATA_W-1:0] TAP_MASK = 24'hE10000,
  parameter logic [DATA_W-1:0] SEED     = 24'hACE1F5
) (
  input  logic              clk,
  input  logic              rst,
  input  scrStrobe_t        strb,
  input  logic [DATA_W-1:0] snkData,
  output logic [DATA_W-1:0] srcData
);
  logic [DATA_W-1:0] lfsrState;
  logic [DATA_W-1:0] lfsrUse;
  logic [DATA_W-1:0] lfsrNext;
  logic              feedback;

  always_comb begin
    lfsrUse  = strb.sop ? SEED : lfsrState;
    feedback = ^(lfsrUse & TAP_MASK);
    lfsrNext = {lfsrUse[DATA_W-2:0], feedback};
    srcData  = snkData ^ (strb.inWindow ? lfsrUse : '0);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      lfsrState <= SEED;
    end else if (strb.fire) begin
      if (strb.inWindow)  lfsrState <= lfsrNext;
      else if (strb.sop)  lfsrState <= SEED;
    end
  end

  assert_lfsr_live_R5: assert property (@(posedge clk) disable iff (rst)
    lfsrState != '0);

  assert_stall_lfsr_R7: assert property (@(posedge clk) disable iff (rst)
    !strb.fire |=> $stable(lfsrState));
endmodule

// File: rtl/pix_xor_stage.sv
module pix_xor_stage
  import pix_xor_pkg::*;
#(
  parameter int          START_IDX = 1000,
  parameter int          END_IDX   = 15000,
  parameter logic [23:0] SEED      = 24'hACE1F5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [23:0] snkData,
  input  logic        snkValid,
  input  logic        snkSop,
  input  logic        snkEop,
  output logic        snkReady,
  output logic [23:0] srcData,
  output logic        srcValid,
  output logic        srcSop,
  output logic        srcEop,
  input  logic        srcReady
);
  localparam int          DATA_W   = 24;
  localparam logic [23:0] TAP_MASK = 24'hE10000;

  scrStrobe_t strb;

  assign srcValid = snkValid;
  assign srcSop   = snkSop;
  assign srcEop   = snkEop;
  assign snkReady = srcReady;

  pix_xor_ctrl #(.START_IDX(START_IDX), .END_IDX(END_IDX)) u_ctrl (
    .clk(clk), .rst(rst), .snkValid(snkValid), .snkSop(snkSop),
    .srcReady(srcReady), .strb(strb)
  );

  pix_xor_dpath #(.DATA_W(DATA_W), .TAP_MASK(TAP_MASK), .SEED(SEED)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .snkData(snkData), .srcData(srcData)
  );

  assert_outside_clean_R4: assert property (@(posedge clk) disable iff (rst)
    !strb.inWindow |-> srcData == snkData);
endmodule

// File: tb/pix_xor_stage_test.sv
module pix_xor_stage_test;
  localparam int          CLK_PERIOD = 10;
  localparam int          S_IDX = 5;
  localparam int          E_IDX = 12;
  localparam logic [23:0] SEED  = 24'hACE1F5;

  logic clk = 0, rst = 1;
  logic [23:0] snkData = '0;
  logic snkValid = 0, snkSop = 0, snkEop = 0, srcReady = 0;
  logic snkReady, srcValid, srcSop, srcEop;
  logic [23:0] srcData;

  int checks = 0, errors = 0;
  int mIdx = 0;
  logic [23:0] mLfsr = SEED;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_xor_stage #(.START_IDX(S_IDX), .END_IDX(E_IDX), .SEED(SEED)) uut (
    .clk(clk), .rst(rst), .snkData(snkData), .snkValid(snkValid),
    .snkSop(snkSop), .snkEop(snkEop), .snkReady(snkReady),
    .srcData(srcData), .srcValid(srcValid), .srcSop(srcSop),
    .srcEop(srcEop), .srcReady(srcReady)
  );

  function automatic logic [23:0] lfsrStep(input logic [23:0] s);
    return {s[22:0], s[23] ^ s[22] ^ s[21] ^ s[16]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Drive one beat until accepted; checks every cycle it is presented
  task automatic sendBeat(input logic [23:0] d, input bit sop, input bit eop, input int stallPct);
    bit accepted = 0;
    logic [23:0] prevOut = '0;
    bit wasStalled = 0;
    while (!accepted) begin
      @(negedge clk);
      snkData  = d; snkSop = sop; snkEop = eop;
      snkValid = ($urandom % 100) >= stallPct;
      srcReady = ($urandom % 100) >= stallPct;
      #1;
      begin
        int idx = sop ? 0 : mIdx;
        logic [23:0] use_ = sop ? SEED : mLfsr;
        bit inW = (idx >= S_IDX) && (idx <= E_IDX);
        logic [23:0] exp = d ^ (inW ? use_ : 24'h0);
        check(srcValid == snkValid && srcSop == sop && srcEop == eop && snkReady == srcReady,
              "R1", {srcValid, srcSop, srcEop, snkReady}, {snkValid, sop, eop, srcReady});
        if (snkValid) begin
          check(srcData == exp, inW ? "R3/R5/R6" : (idx > E_IDX ? "R4/R8" : "R4"), srcData, exp);
          if (wasStalled) check(srcData == prevOut, "R7", srcData, prevOut);
        end
        if (snkValid && srcReady) begin
          accepted = 1;
          if (inW) mLfsr = lfsrStep(use_);
          else if (sop) mLfsr = SEED;
          mIdx = idx + 1;
        end else if (snkValid) begin
          wasStalled = 1;
          prevOut = srcData;
        end
      end
    end
  endtask

  task automatic sendFrame(input int len, input int stallPct);
    for (int i = 0; i < len; i++)
      sendBeat(24'($urandom), i == 0, i == len - 1, stallPct);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check(srcValid == 1'b0 && snkReady == 1'b0, "R1 reset", {srcValid, snkReady}, 2'b00);
    rst = 0;
    // R2 R6: frame exactly ending on window end, then past it
    sendFrame(E_IDX + 1, 0);
    sendFrame(E_IDX + 1, 40);
    // R8: long frame beyond window
    sendFrame(40, 30);
    // short frames: before window, cut inside window
    sendFrame(3, 50);
    sendFrame(S_IDX + 1, 50);
    sendFrame(9, 60);
    // R2 R6: sop arriving mid-window, no eop on previous frame
    for (int i = 0; i < 8; i++) sendBeat(24'($urandom), i == 0, 1'b0, 30);
    sendFrame(20, 70);
    // near-exhaustive sweep of frame lengths under stalls
    for (int len = 1; len <= E_IDX + 4; len++) sendFrame(len, (len * 13) % 80);
    // constant data pattern: output shows the key directly
    for (int i = 0; i < 16; i++) sendBeat(24'h000000, i == 0, i == 15, 20);
    @(negedge clk); snkValid = 0; srcReady = 1; #1;
    check(srcValid == 0 && snkReady == 1, "R1 idle", {srcValid, snkReady}, 2'b01);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule